// File: doc/BRIEF.md
# Multiplier-Free Decimate-by-Eight Low-Pass Filter

This block is a fixed-coefficient low-pass FIR filter for one real sample stream. Each clock it may accept a word that holds eight consecutive input samples, and it returns one filtered sample per accepted word. That output is exactly the sample a full-rate serial filter would give if only every eighth of its outputs were kept. A complex down-converter uses two instances, one on the in-phase path and one on the quadrature path.

The block keeps a history of the sixteen most recent words, which is 128 samples. The 128 coefficients are integer constants computed at elaboration. Each coefficient is recoded into signed digits of value -1, 0 or +1, with no two neighbouring digits both nonzero. For every digit position, one adder tree adds or subtracts the samples whose coefficient has a nonzero digit there. The weighted plane sums are then added with shifts, and the result is rounded to the output width. No multipliers are used.

Top module: `csd_decim_fir`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been sampled high, `out_valid` is 0 and `out_data` is 0.
- R2: Lane j of `in_data` is bits [8j+7:8j], holding an 8-bit two's-complement sample. Within a word, lane 0 is the oldest sample and lane 7 is the newest. Later words are later in time.
- R3: For accepted word n, the sample before rounding is y = sum over k = 0..127 of h[k]·x[8n+7-k]. Here x[8n+j] is lane j of word n, and h[k] = ((k+1)·(128-k))/5 - 60, with truncating integer division. Every coefficient fits in 11 signed bits.
- R4: `out_data` is the 16-bit two's-complement value floor((y + 1024) / 2048). This is the upper 16 bits of the 27-bit sum, rounded half up, and it applies to negative sums as well.
- R5: `out_valid` is high exactly four cycles after each cycle in which `in_valid` is high, and at no other time. Results come out in the order the words were accepted.
- R6: A cycle with `in_valid` low does not move the history, whatever `in_data` holds. Results are the same as if the accepted words had arrived back to back.
- R7: While `out_valid` is low, `out_data` keeps its last value.
- R8: Reset clears the history, so samples from before the reset count as zero.
- R9: Full-scale inputs (all +127, all -128, or a mix of the two) give the exact value of R3 and R4 without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks an input word as accepted |
| in_data | input | 64 | Eight packed signed samples, lane 0 oldest |
| out_valid | output | 1 | Marks a new decimated output |
| out_data | output | 16 | Rounded signed filter output |

## Verification
The assertions assume that `in_valid` is low whenever `rst` is high. The stimulus keeps it low throughout every reset and only raises it once reset has been released. The no-overflow property depends on inputs staying inside the signed 8-bit range, which holds by construction. The bench pushes full-scale words of both signs to bring the rounded result as close to the limit as the coefficients allow. Cycles with `in_valid` low carry random data, so that anything leaking into the history shows up as a mismatch against the gapless model.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;

   // Integer low-pass coefficient for tap k of an n_taps filter.
   function automatic int fir_coef(input int k, input int n_taps);
      return ((k + 1) * (n_taps - k)) / 5 - 60;
   endfunction

   // Canonic signed digit recoding: mask of +1 digits (want_neg = 0)
   // or of -1 digits (want_neg = 1).
   function automatic logic [31:0] csd_mask(input int value, input bit want_neg);
      int x;
      int d;
      logic [31:0] m;
      x = value;
      m = '0;
      for (int i = 0; i < 32; i++) begin
         if ((x & 1) != 0) begin
            d = ((x & 3) == 3) ? -1 : 1;
            if ((d < 0) == want_neg) m[i] = 1'b1;
            x = (x - d) >>> 1;
         end else begin
            x = x >>> 1;
         end
      end
      return m;
   endfunction

endpackage

// File: rtl/csd_fir_history.sv
module csd_fir_history #(
   parameter int LANES = 8,
   parameter int DEPTH = 16,
   parameter int IN_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          in_valid,
   input  logic [LANES*IN_W-1:0]         in_data,
   output logic [DEPTH*LANES*IN_W-1:0]   hist
);
   localparam int WORD_W = LANES * IN_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("csd_fir_history: DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] word_q [DEPTH];

   for (genvar t = 0; t < DEPTH; t++) begin : g_stage
      if (t == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst)           word_q[0] <= '0;
            else if (in_valid) word_q[0] <= in_data;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst)           word_q[t] <= '0;
            else if (in_valid) word_q[t] <= word_q[t-1];
         end
      end
      assign hist[t*WORD_W +: WORD_W] = word_q[t];
   end

   // R2: an accepted word moves the previous newest word one step older
   p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> hist[WORD_W +: WORD_W] == $past(hist[0 +: WORD_W]));

   // R6: idle cycles leave the history untouched
   p_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(hist));

endmodule

// File: rtl/csd_fir_plane.sv
module csd_fir_plane #(
   parameter int LANES  = 8,
   parameter int DEPTH  = 16,
   parameter int IN_W   = 8,
   parameter int PLANE  = 0,
   parameter int PS_W   = 16
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic [DEPTH*LANES*IN_W-1:0]        hist,
   output logic signed [PS_W-1:0]             plane_q
);
   localparam int NTAP = LANES * DEPTH;

   logic signed [PS_W-1:0] term [NTAP];
   logic signed [PS_W-1:0] sum_d;

   for (genvar t = 0; t < DEPTH; t++) begin : g_word
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         localparam int          K  = t * LANES + (LANES - 1 - j);
         localparam int          C  = csd_fir_pkg::fir_coef(K, NTAP);
         localparam logic [31:0] PM = csd_fir_pkg::csd_mask(C, 1'b0);
         localparam logic [31:0] NM = csd_fir_pkg::csd_mask(C, 1'b1);
         logic signed [PS_W-1:0] smp;
         assign smp = PS_W'($signed(hist[(t*LANES + j)*IN_W +: IN_W]));
         if (PM[PLANE]) begin : g_add
            assign term[t*LANES + j] = smp;
         end else if (NM[PLANE]) begin : g_sub
            assign term[t*LANES + j] = -smp;
         end else begin : g_none
            assign term[t*LANES + j] = '0;
         end
      end
   end

   always_comb begin
      sum_d = '0;
      for (int i = 0; i < NTAP; i++) sum_d = sum_d + term[i];
   end

   always_ff @(posedge clk) begin
      if (rst) plane_q <= '0;
      else     plane_q <= sum_d;
   end

endmodule

// File: rtl/csd_fir_combine.sv
module csd_fir_combine #(
   parameter int PLANES = 11,
   parameter int PS_W   = 16,
   parameter int ACC_W  = 27,
   parameter int OUT_W  = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [PLANES*PS_W-1:0]     planes,
   output logic                       out_valid,
   output logic [OUT_W-1:0]           out_data
);
   localparam int SHIFT = ACC_W - OUT_W;
   localparam logic [ACC_W:0] HALF = {{ACC_W{1'b0}}, 1'b1} << (SHIFT - 1);

   if (SHIFT < 1) begin : g_bad_shift
      $error("csd_fir_combine: ACC_W must exceed OUT_W");
   end

   logic signed [ACC_W-1:0] acc_d, acc_q;
   logic                    acc_v;
   logic [ACC_W:0]          rnd_full;
   logic signed [ACC_W:0]   scaled;

   always_comb begin
      acc_d = '0;
      for (int p = 0; p < PLANES; p++)
         acc_d = acc_d + (ACC_W'($signed(planes[p*PS_W +: PS_W])) <<< p);
   end

   assign rnd_full = {acc_q[ACC_W-1], acc_q} + HALF;
   assign scaled   = $signed(rnd_full) >>> SHIFT;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q     <= '0;
         acc_v     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         acc_q     <= acc_d;
         acc_v     <= in_valid;
         out_valid <= acc_v;
         if (acc_v) out_data <= scaled[OUT_W-1:0];
      end
   end

   // R9: the rounded value fits the output width
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
      acc_v |-> ((&scaled[ACC_W:OUT_W-1]) || !(|scaled[ACC_W:OUT_W-1])));

   // R7: output holds when no new result is loaded
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !acc_v |=> $stable(out_data));

endmodule

// File: rtl/csd_decim_fir.sv
module csd_decim_fir #(
   parameter int LANES  = 8,
   parameter int DEPTH  = 16,
   parameter int IN_W   = 8,
   parameter int COEF_W = 11,
   parameter int OUT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [LANES*IN_W-1:0]   in_data,
   output logic                    out_valid,
   output logic [OUT_W-1:0]        out_data
);
   localparam int NTAP    = LANES * DEPTH;
   localparam int LOG_N   = $clog2(NTAP);
   localparam int PS_W    = IN_W + LOG_N + 1;
   localparam int ACC_W   = IN_W + COEF_W + LOG_N + 1;
   localparam int PLANES  = COEF_W;
   localparam int LATENCY = 4;

   if (LANES < 1 || IN_W < 2 || COEF_W < 2) begin : g_bad_dims
      $error("csd_decim_fir: LANES, IN_W and COEF_W out of range");
   end

   // Every coefficient must fit COEF_W signed bits and recode into COEF_W
   // non-adjacent signed digits.
   for (genvar k = 0; k < NTAP; k++) begin : g_coef_chk
      localparam int          C  = csd_fir_pkg::fir_coef(k, NTAP);
      localparam logic [31:0] PM = csd_fir_pkg::csd_mask(C, 1'b0);
      localparam logic [31:0] NM = csd_fir_pkg::csd_mask(C, 1'b1);
      localparam logic [31:0] NZ = PM | NM;
      if (C > 2**(COEF_W-1) - 1 || C < -(2**(COEF_W-1))) begin : g_range
         $error("csd_decim_fir: coefficient exceeds COEF_W");
      end
      if ((NZ >> COEF_W) != 0 || (NZ & (NZ >> 1)) != 0) begin : g_digits
         $error("csd_decim_fir: signed-digit recoding invalid");
      end
   end

   logic [DEPTH*LANES*IN_W-1:0] hist;
   logic [PLANES*PS_W-1:0]      plane_flat;
   logic                        v_hist, v_plane;

   csd_fir_history #(.LANES(LANES), .DEPTH(DEPTH), .IN_W(IN_W)) u_hist (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_data  (in_data),
      .hist     (hist)
   );

   for (genvar p = 0; p < PLANES; p++) begin : g_plane
      csd_fir_plane #(
         .LANES (LANES), .DEPTH (DEPTH), .IN_W (IN_W),
         .PLANE (p),     .PS_W  (PS_W)
      ) u_plane (
         .clk     (clk),
         .rst     (rst),
         .hist    (hist),
         .plane_q (plane_flat[p*PS_W +: PS_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_hist  <= 1'b0;
         v_plane <= 1'b0;
      end else begin
         v_hist  <= in_valid;
         v_plane <= v_hist;
      end
   end

   csd_fir_combine #(
      .PLANES (PLANES), .PS_W (PS_W), .ACC_W (ACC_W), .OUT_W (OUT_W)
   ) u_comb (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (v_plane),
      .planes    (plane_flat),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // R1: reset clears the outputs
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

   // R5: every accepted word yields a result LATENCY cycles later
   p_latency_r5: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ##LATENCY out_valid);

   // R5: no result without an accepted word LATENCY cycles earlier
   p_origin_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, LATENCY));

endmodule

// File: tb/tb_csd_decim_fir.sv
module tb_csd_decim_fir;
   localparam int LANES = 8;
   localparam int IN_W  = 8;
   localparam int OUT_W = 16;
   localparam int NTAP  = 128;
   localparam int SHIFT = 11;
   localparam int LAT   = 4;

   logic                  clk = 1'b0;
   logic                  rst = 1'b1;
   logic                  in_valid = 1'b0;
   logic [LANES*IN_W-1:0] in_data = '0;
   logic                  out_valid;
   logic [OUT_W-1:0]      out_data;

   csd_decim_fir dut (
      .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
      .out_valid (out_valid), .out_data (out_data)
   );

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     finished = 1'b0;
   longint model_x [NTAP];
   longint exp_q [$];
   int     stamp_q [$];
   string  tag_q [$];
   logic [OUT_W-1:0] last_out = '0;
   logic [31:0] lf = 32'hACE1_1234;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic longint coef(input int k);
      return longint'(((k + 1) * (NTAP - k)) / 5 - 60);
   endfunction

   function automatic logic [63:0] rnd64();
      for (int i = 0; i < 64; i++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      return {lf, lf ^ 32'h5A5A_C3C3};
   endfunction

   // R3/R4 model: shift in a word, form the sum, round half up
   function automatic longint model_push(input logic [63:0] w);
      longint y;
      for (int k = NTAP - 1; k >= LANES; k--) model_x[k] = model_x[k - LANES];
      for (int j = 0; j < LANES; j++) model_x[LANES - 1 - j] = longint'($signed(w[j*IN_W +: IN_W]));
      y = 0;
      for (int k = 0; k < NTAP; k++) y += coef(k) * model_x[k];
      return (y + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
   endfunction

   task automatic send(input logic [63:0] w, input string tag, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      exp_q.push_back(model_push(w));
      stamp_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = rnd64();
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = rnd64();
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
      check(out_data == '0, "R1 out_data in reset", longint'(out_data), 0);
      for (int k = 0; k < NTAP; k++) model_x[k] = 0;
      last_out = '0;
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (!rst && !finished) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5 output without accepted word", longint'($signed(out_data)), 0);
            end else begin
               longint e;
               int     s;
               string  t;
               e = exp_q.pop_front();
               s = stamp_q.pop_front();
               t = tag_q.pop_front();
               check(longint'($signed(out_data)) == e, t, longint'($signed(out_data)), e);
               check(cyc == s, "R5 latency", cyc, s);
            end
            last_out = out_data;
         end else begin
            check(out_data == last_out, "R7 hold while idle",
                  longint'($signed(out_data)), longint'($signed(last_out)));
         end
      end
   end

   initial begin
      for (int k = 0; k < NTAP; k++) model_x[k] = 0;
      do_reset();
      // R3: impulse on the newest lane traces coefficients
      send({8'd127, 56'd0}, "R3 impulse", 0);
      for (int i = 0; i < 17; i++) send('0, "R3 impulse tail", 0);
      // R4: negative impulse on the oldest lane, rounding of negative sums
      send({56'd0, 8'h80}, "R4 negative rounding", 0);
      for (int i = 0; i < 17; i++) send('0, "R4 negative tail", 0);
      // R2: middle lane impulse checks lane order
      send({32'd0, 8'd100, 24'd0}, "R2 lane order", 0);
      for (int i = 0; i < 17; i++) send('0, "R2 lane tail", 0);
      // R9: full scale both signs and mixed
      for (int i = 0; i < 20; i++) send({8{8'h7F}}, "R9 full positive", 0);
      for (int i = 0; i < 20; i++) send({8{8'h80}}, "R9 full negative", 0);
      for (int i = 0; i < 20; i++) send({4{8'h80, 8'h7F}}, "R9 mixed full scale", 0);
      // R3: random words back to back
      for (int i = 0; i < 40; i++) send(rnd64(), "R3 random", 0);
      // R6: random words with idle gaps carrying garbage
      for (int i = 0; i < 40; i++) send(rnd64(), "R6 gaps ignored", 1 + (i % 3));
      idle(12);
      check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
      // R8: reset clears history, then impulse response starts clean
      do_reset();
      send({8'd127, 56'd0}, "R8 after reset", 0);
      for (int i = 0; i < 5; i++) send(rnd64(), "R8 after reset", 0);
      idle(12);
      check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule